// File: doc/BRIEF.md
# Decade Pulse-Width Generator

This block produces a pulse train with a fixed period of one hundred input steps. The high time of each period is set by a two-digit decimal setpoint. Each cycle in which the step enable is high advances a two-digit BCD counter. The counter runs from 00 to 99 and then starts again at 00.

The count is compared with the setpoint as one packed BCD word. The compare starts at the most significant bit, and a lower bit is looked at only while every bit above it matches. The output is high while the count is below the setpoint. A setpoint of D therefore gives D high steps in every period of 100.

The setpoint inputs are sampled only when the count wraps from 99 to 00. A change to them never cuts a period short or stretches it. Making the setpoint, debouncing a key and driving a display are done outside the block.

Top module: `decade_pwm`

## Requirements
- R1: On every clock edge with `step_en` high, the units digit `count_o[3:0]` advances by one. With `step_en` low, both count digits hold their value.
- R2: When the units digit advances from 9, it returns to 0 and the tens digit `count_o[7:4]` advances once. An enabled step at 99 gives 00. Both digits always stay in the range 0 to 9.
- R3: A clock edge with `rst` high sets the count to 00 and loads the setpoint register from `setpoint_i`, clamped as in R7.
- R4: `cmp_gt` is 1 exactly when the count is greater than the held setpoint. A higher tens digit alone is enough, for example a count of 90 against a setpoint of 30.
- R5: `cmp_eq` is 1 exactly when the count equals the held setpoint. At most one of `cmp_gt`, `cmp_eq` and `pulse_out` is high at any time.
- R6: `pulse_out` is 1 exactly when the count is below the held setpoint D. This gives D high steps per 100, so D=0 keeps the output low and D=99 gives 99 high steps.
- R7: A setpoint digit code from 10 to 15 (tens in `setpoint_i[7:4]`, units in `setpoint_i[3:0]`) is treated as 9.
- R8: The setpoint register loads only on reset and on the enabled step from 99 to 00. A change of `setpoint_i` at any other time has no effect until the next wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Input pulse, sampled as a one-cycle step enable |
| setpoint_i | input | 8 | BCD setpoint: tens digit in [7:4], units digit in [3:0] |
| pulse_out | output | 1 | Pulse output, high while count < setpoint |
| cmp_gt | output | 1 | Count greater than the held setpoint |
| cmp_eq | output | 1 | Count equal to the held setpoint |
| count_o | output | 8 | Current BCD count: tens digit in [7:4], units digit in [3:0] |

## Verification
The assertions check on every cycle that:
- each count digit stays between 0 and 9;
- the count holds while the step enable is low, and a 9 rolls over to 0;
- reset gives 00;
- the held setpoint digits are clamped and change only at a wrap;
- exactly one of greater, equal and less is reported;
- a zero setpoint keeps the output low.

Only the bench's scenarios show that each whole period has exactly D high steps for a range of setpoints, including the clamped ones. They also show that a setpoint change in mid-period takes effect only after the next wrap, and that the greater-than flag follows the worked 90 against 30 example.

// File: rtl/decade_pwm_pkg.sv
package decade_pwm_pkg;

  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DIGIT_TOP = 4'd9;

  typedef logic [DIGIT_W-1:0] digit_t;

  // Restrict an arbitrary 4-bit code to a legal decimal digit.
  function automatic digit_t digit_clamp(input digit_t d);
    return (d > DIGIT_TOP) ? DIGIT_TOP : d;
  endfunction

  // Next value of one decade digit when it is stepped.
  function automatic digit_t digit_next(input digit_t d);
    return (d >= DIGIT_TOP) ? '0 : digit_t'(d + 1'b1);
  endfunction

  // True when a step on this digit rolls it over.
  function automatic logic digit_at_top(input digit_t d);
    return d == DIGIT_TOP;
  endfunction

endpackage

// File: rtl/bcd_digit_counter.sv
module bcd_digit_counter
  import decade_pwm_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   step_i,
  output digit_t digit_o,
  output logic   carry_o
);

  digit_t digit_q;

  always_ff @(posedge clk) begin
    if (rst)         digit_q <= '0;
    else if (step_i) digit_q <= digit_next(digit_q);
  end

  assign digit_o = digit_q;
  assign carry_o = step_i & digit_at_top(digit_q);

  assert_digit_range_R2: assert property (@(posedge clk) disable iff (rst)
    digit_q <= 4'd9);

  assert_digit_roll_R2: assert property (@(posedge clk) disable iff (rst)
    (step_i && digit_q == 4'd9) |=> (digit_q == 4'd0));

  assert_digit_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(digit_q));

endmodule

// File: rtl/bcd_decade_chain.sv
module bcd_decade_chain
  import decade_pwm_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int CW = DIGITS * DIGIT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  output logic [CW-1:0] count_o,
  output logic          wrap_o
);

  logic [DIGITS:0] carry;

  assign carry[0] = step_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    digit_t d;
    bcd_digit_counter u_digit (
      .clk     (clk),
      .rst     (rst),
      .step_i  (carry[g]),
      .digit_o (d),
      .carry_o (carry[g+1])
    );
    assign count_o[g*DIGIT_W +: DIGIT_W] = d;
  end

  // The last digit's carry marks the step from all-nines back to zero.
  assign wrap_o = carry[DIGITS];

endmodule

// File: rtl/setpoint_holder.sv
module setpoint_holder
  import decade_pwm_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int CW = DIGITS * DIGIT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] raw_i,
  output logic [CW-1:0] sp_o
);

  logic [CW-1:0] clamped;
  logic [CW-1:0] sp_q;

  for (genvar g = 0; g < DIGITS; g++) begin : g_clamp
    assign clamped[g*DIGIT_W +: DIGIT_W] = digit_clamp(raw_i[g*DIGIT_W +: DIGIT_W]);

    assert_sp_digit_legal_R7: assert property (@(posedge clk) disable iff (rst)
      sp_q[g*DIGIT_W +: DIGIT_W] <= 4'd9);
  end

  always_ff @(posedge clk) begin
    if (rst || load_i) sp_q <= clamped;
  end

  assign sp_o = sp_q;

  assert_sp_only_at_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(sp_q));

endmodule

// File: rtl/msb_first_compare.sv
module msb_first_compare #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         gt_o,
  output logic         eq_o,
  output logic         lt_o
);

  // Scan from the top bit; the first differing bit decides the result.
  always_comb begin
    logic decided;
    decided = 1'b0;
    gt_o    = 1'b0;
    lt_o    = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!decided && (a_i[i] != b_i[i])) begin
        decided = 1'b1;
        gt_o    = a_i[i];
        lt_o    = b_i[i];
      end
    end
    eq_o = !decided;
  end

endmodule

// File: rtl/decade_pwm.sv
module decade_pwm
  import decade_pwm_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int CW = DIGITS * DIGIT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_en,
  input  logic [CW-1:0] setpoint_i,
  output logic          pulse_out,
  output logic          cmp_gt,
  output logic          cmp_eq,
  output logic [CW-1:0] count_o
);

  logic [CW-1:0] count_w;
  logic [CW-1:0] sp_w;
  logic          wrap_w;
  logic          lt_w;

  bcd_decade_chain #(.DIGITS(DIGITS)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .step_i  (step_en),
    .count_o (count_w),
    .wrap_o  (wrap_w)
  );

  setpoint_holder #(.DIGITS(DIGITS)) u_sp (
    .clk    (clk),
    .rst    (rst),
    .load_i (wrap_w),
    .raw_i  (setpoint_i),
    .sp_o   (sp_w)
  );

  msb_first_compare #(.W(CW)) u_cmp (
    .a_i  (count_w),
    .b_i  (sp_w),
    .gt_o (cmp_gt),
    .eq_o (cmp_eq),
    .lt_o (lt_w)
  );

  assign pulse_out = lt_w;
  assign count_o   = count_w;

  assert_reset_zero_R3: assert property (@(posedge clk)
    rst |=> (count_w == '0));

  assert_single_result_R5: assert property (@(posedge clk) disable iff (rst)
    $countones({cmp_gt, cmp_eq, lt_w}) == 1);

  assert_zero_sp_low_R6: assert property (@(posedge clk) disable iff (rst)
    (sp_w == '0) |-> !pulse_out);

  assert_top_digit_decides_R4: assert property (@(posedge clk) disable iff (rst)
    (count_w[CW-1 -: DIGIT_W] > sp_w[CW-1 -: DIGIT_W]) |-> cmp_gt);

endmodule

// File: tb/test_decade_pwm.sv
`timescale 1ns/1ps
module test_decade_pwm;

  localparam time TCLK = 20ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_en = 1'b0;
  logic [7:0] setpoint_i = 8'h00;
  logic       pulse_out, cmp_gt, cmp_eq;
  logic [7:0] count_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;
  int m_cnt = 0;
  int m_sp = 0;

  always #(TCLK/2) clk = ~clk;

  decade_pwm i_decade_pwm (
    .clk        (clk),
    .rst        (rst),
    .step_en    (step_en),
    .setpoint_i (setpoint_i),
    .pulse_out  (pulse_out),
    .cmp_gt     (cmp_gt),
    .cmp_eq     (cmp_eq),
    .count_o    (count_o)
  );

  // Vectors: tens code, units code, expected high steps per period.
  localparam logic [15:0] VEC [8] = '{
    {4'h3, 4'h0, 8'd30}, {4'h0, 4'h0, 8'd0},  {4'h9, 4'h9, 8'd99},
    {4'h5, 4'h0, 8'd50}, {4'h1, 4'h7, 8'd17}, {4'h0, 4'h1, 8'd1},
    {4'hF, 4'h3, 8'd93}, {4'h2, 4'hC, 8'd29}
  };

  function automatic int sp_value(input logic [7:0] raw);
    int t, u;
    t = (raw[7:4] > 4'd9) ? 9 : int'(raw[7:4]);
    u = (raw[3:0] > 4'd9) ? 9 : int'(raw[3:0]);
    return t * 10 + u;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d (model count %0d sp %0d)",
               tag, act, exp, m_cnt, m_sp);
    end
  endtask

  task automatic check_all();
    chk("R2 count", int'(count_o[7:4]) * 10 + int'(count_o[3:0]), m_cnt);
    chk("R4 gt", int'(cmp_gt), int'(m_cnt > m_sp));
    chk("R5 eq", int'(cmp_eq), int'(m_cnt == m_sp));
    chk("R6 pulse", int'(pulse_out), int'(m_cnt < m_sp));
  endtask

  // Called at a falling edge; leaves the bench at the next falling edge.
  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    m_cnt = 0;
    m_sp = sp_value(setpoint_i);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input logic en);
    step_en = en;
    @(posedge clk);
    if (en) begin
      if (m_cnt == 99) begin
        m_cnt = 0;
        m_sp = sp_value(setpoint_i);
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
    @(negedge clk);
    step_en = 1'b0;
    check_all();
  endtask

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int high;
    @(negedge clk);

    // R3: reset state
    setpoint_i = 8'h30;
    do_reset();
    chk("R3 count after reset", int'(count_o), 0);
    chk("R3 pulse after reset (sp 30)", int'(pulse_out), 1);
    check_all();

    // Table walk: one full period per setpoint (R6, R7).
    for (int v = 0; v < 8; v++) begin
      setpoint_i = VEC[v][15:8];
      do_reset();
      high = 0;
      for (int s = 0; s < 100; s++) begin
        if (pulse_out) high++;
        step(1'b1);
      end
      chk("R6/R7 high steps per period", high, int'(VEC[v][7:0]));
      chk("R2 wrap to 00", int'(count_o), 0);
    end

    // R1: hold with enable low, mixed enable pattern
    setpoint_i = 8'h45;
    do_reset();
    for (int s = 0; s < 13; s++) step(1'b1);
    for (int s = 0; s < 5; s++) step(1'b0);
    chk("R1 hold at 13", int'(count_o), 8'h13);
    for (int s = 0; s < 20; s++) step(s[0]);
    chk("R1 alternating steps", int'(count_o), 8'h23);

    // R2: units carry 09 -> 10
    do_reset();
    for (int s = 0; s < 9; s++) step(1'b1);
    chk("R2 before carry", int'(count_o), 8'h09);
    step(1'b1);
    chk("R2 carry into tens", int'(count_o), 8'h10);

    // R3: reset in mid-count
    for (int s = 0; s < 27; s++) step(1'b1);
    do_reset();
    chk("R3 mid-count reset", int'(count_o), 0);

    // R4: count 90 against setpoint 30
    setpoint_i = 8'h30;
    do_reset();
    for (int s = 0; s < 90; s++) step(1'b1);
    chk("R4 90 vs 30 gt", int'(cmp_gt), 1);
    chk("R5 90 vs 30 eq", int'(cmp_eq), 0);
    chk("R6 90 vs 30 pulse", int'(pulse_out), 0);

    // R8: mid-period setpoint change waits for the wrap
    setpoint_i = 8'h30;
    do_reset();
    for (int s = 0; s < 20; s++) step(1'b1);
    setpoint_i = 8'h80;
    for (int s = 0; s < 30; s++) step(1'b1);
    chk("R8 old setpoint still active at 50", int'(pulse_out), 0);
    for (int s = 0; s < 50; s++) step(1'b1);
    chk("R8 wrap reached", int'(count_o), 0);
    for (int s = 0; s < 50; s++) step(1'b1);
    chk("R8 new setpoint active at 50", int'(pulse_out), 1);
    for (int s = 0; s < 30; s++) step(1'b1);
    chk("R5 equal at 80", int'(cmp_eq), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule